// File: doc/BRIEF.md
# PLL lock status timer

This block produces the lock indication for a phase-locked loop whose lock time is not sensed but programmed. A single bus write loads the loop's multiplier, divider and a lock-wait count. The write crosses into the slow-clock domain through a toggle request and a two-flop synchronizer. There a down-counter waits the programmed number of slow-clock cycles and then raises a lock flag.

The lock flag comes back to the bus clock through a second synchronizer. The bus side shows it as a status bit and gates it with an interrupt-enable bit to drive an interrupt line. A write that alters the multiplier or divider clears the status bit in the next bus cycle and starts a new wait. A write that only alters the wait count leaves an established lock alone.

The loop itself is not modelled. Its nominal frequency ratio is given as the multiplier plus one, and it is valid only while both the multiplier and the divider are non-zero. The input clock is the main clock.

Top module: `pll_lock_timer`

## Requirements
- R1: One `cfg_we` cycle stores `cfg_mul`, `cfg_div` and `cfg_cnt` together, and all three appear on `mul_q`, `div_q` and `cnt_q` after that bus edge.
- R2: The slow-clock edge that loads the wait is the third rising `slck` edge after the bus edge of the write. `lock_status` goes high in the bus domain after slow edge number `cnt + 3`, counted from the write, and is low before that. A count of 8 gives edge 11.
- R3: A wait count of zero sets the lock on the load edge itself, so the status goes high after slow edge number 3.
- R4: A write whose `cfg_mul` or `cfg_div` differs from the stored value drives `lock_status` low in the bus cycle after the write and restarts the wait with the new count.
- R5: A write whose multiplier and divider both equal the stored values leaves an already-high `lock_status` high. Only the stored count changes.
- R6: `irq` is high exactly when `lock_status` is high and the interrupt-enable bit is set. `ien_set` sets the bit and `ien_clr` clears it, each from the next bus cycle. When both strobes are asserted in the same cycle, the clear wins.
- R7: `pll_en` is high when the stored multiplier and divider are both non-zero. `mult_factor` is then the stored multiplier plus one, and zero otherwise.
- R8: While and after reset, before any write, `lock_status`, `irq`, `pll_en`, `mult_factor` and the three stored fields are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| slck | input | 1 | Slow clock that times the lock wait |
| cfg_we | input | 1 | Configuration write strobe, one bus cycle |
| cfg_mul | input | MUL_W | Multiplier field of the write |
| cfg_div | input | DIV_W | Divider field of the write |
| cfg_cnt | input | CNT_W | Lock-wait count of the write, in slow cycles |
| ien_set | input | 1 | Sets the lock interrupt enable |
| ien_clr | input | 1 | Clears the lock interrupt enable |
| mul_q | output | MUL_W | Stored multiplier |
| div_q | output | DIV_W | Stored divider |
| cnt_q | output | CNT_W | Stored wait count |
| pll_en | output | 1 | Multiplier and divider both non-zero |
| mult_factor | output | MUL_W+1 | Nominal output-to-input ratio, zero when disabled |
| lock_status | output | 1 | Lock flag in the bus domain |
| irq | output | 1 | Lock interrupt |

## Verification
A corrupted wait counter or a lost toggle shows at the ports as a status rise on the wrong slow edge, or as no rise at all. The bench measures this to the exact edge, within at most 66 slow cycles of the write. A stale tag comparison shows up in the bus cycle right after a configuration write: the status either fails to drop on a change, or drops when nothing that matters changed. A wrong enable register is visible on `irq` one bus cycle after a strobe.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

   // operation applied to the interrupt enable bit in one bus cycle
   typedef enum logic [1:0] {
      IEN_KEEP = 2'd0,
      IEN_ON   = 2'd1,
      IEN_OFF  = 2'd2
   } ien_op_t;

   function automatic ien_op_t ien_decode(input logic set_s, input logic clr_s,
                                          input bit clear_first);
      ien_op_t op;
      if (set_s && clr_s)   op = clear_first ? IEN_OFF : IEN_ON;
      else if (clr_s)       op = IEN_OFF;
      else if (set_s)       op = IEN_ON;
      else                  op = IEN_KEEP;
      return op;
   endfunction

endpackage

// File: rtl/plt_sync.sv
module plt_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_depth
      $error("plt_sync needs at least two stages");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/plt_lock_counter.sv
module plt_lock_counter #(
   parameter int CNT_W = 6
) (
   input  logic             slck,
   input  logic             rst_n,
   input  logic             req_s,
   input  logic             chg_in,
   input  logic [CNT_W-1:0] cnt_in,
   output logic             lock,
   output logic             tag,
   output logic             reload
);

   logic             req_d;
   logic [CNT_W-1:0] remain;
   logic             load_ev;
   logic             new_ratio;

   assign load_ev   = (req_s != req_d);
   assign new_ratio = (chg_in != tag);
   // an established lock survives a write that did not touch the ratio
   assign reload    = load_ev && (new_ratio || !lock);

   always_ff @(posedge slck or negedge rst_n) begin
      if (!rst_n) begin
         req_d  <= 1'b0;
         remain <= '0;
         lock   <= 1'b0;
         tag    <= 1'b0;
      end else begin
         req_d <= req_s;
         if (reload) begin
            tag    <= chg_in;
            remain <= cnt_in;
            lock   <= (cnt_in == '0);
         end else if (!lock && remain != '0) begin
            remain <= remain - 1'b1;
            if (remain == CNT_W'(1)) lock <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/plt_bus_regs.sv
module plt_bus_regs
   import pll_lock_pkg::*;
#(
   parameter int MUL_W     = 11,
   parameter int DIV_W     = 8,
   parameter int CNT_W     = 6,
   parameter bit CLR_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [MUL_W-1:0] cfg_mul,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic [CNT_W-1:0] cfg_cnt,
   input  logic             ien_set,
   input  logic             ien_clr,
   input  logic             lock_s,
   input  logic             tag_s,
   output logic [MUL_W-1:0] mul_q,
   output logic [DIV_W-1:0] div_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             req_tgl,
   output logic             chg_tgl,
   output logic             pll_en,
   output logic [MUL_W:0]   mult_factor,
   output logic             lock_status,
   output logic             irq
);

   logic    ratio_moves;
   logic    match_now;
   logic    match_q;
   logic    ien_q;
   ien_op_t ien_op;

   assign ratio_moves = (cfg_mul != mul_q) || (cfg_div != div_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mul_q   <= '0;
         div_q   <= '0;
         cnt_q   <= '0;
         req_tgl <= 1'b0;
         chg_tgl <= 1'b0;
      end else if (cfg_we) begin
         mul_q   <= cfg_mul;
         div_q   <= cfg_div;
         cnt_q   <= cfg_cnt;
         req_tgl <= ~req_tgl;
         if (ratio_moves) chg_tgl <= ~chg_tgl;
      end
   end

   // the echoed tag must match now and one cycle ago: covers skew between
   // the two synchronized bits without delaying the drop on a ratio change
   assign match_now = (tag_s == chg_tgl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_q <= 1'b0;
      else        match_q <= match_now;
   end

   assign lock_status = lock_s && match_now && match_q;

   assign ien_op = ien_decode(ien_set, ien_clr, CLR_FIRST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ien_q <= 1'b0;
      else begin
         case (ien_op)
            IEN_ON:  ien_q <= 1'b1;
            IEN_OFF: ien_q <= 1'b0;
            default: ien_q <= ien_q;
         endcase
      end
   end

   assign irq = lock_status && ien_q;

   assign pll_en      = (mul_q != '0) && (div_q != '0);
   assign mult_factor = pll_en ? ({1'b0, mul_q} + 1'b1) : '0;

endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
   parameter int MUL_W       = 11,
   parameter int DIV_W       = 8,
   parameter int CNT_W       = 6,
   parameter int SYNC_STAGES = 2,
   parameter bit CLR_FIRST   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slck,
   input  logic             cfg_we,
   input  logic [MUL_W-1:0] cfg_mul,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic [CNT_W-1:0] cfg_cnt,
   input  logic             ien_set,
   input  logic             ien_clr,
   output logic [MUL_W-1:0] mul_q,
   output logic [DIV_W-1:0] div_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             pll_en,
   output logic [MUL_W:0]   mult_factor,
   output logic             lock_status,
   output logic             irq
);

   localparam int BACK_W = 2;

   if (MUL_W < 1 || DIV_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("pll_lock_timer field widths must be positive");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pll_lock_timer needs two or more synchronizer stages");
   end

   logic              req_tgl;
   logic              chg_tgl;
   logic              req_s;
   logic              lock_raw;
   logic              tag_raw;
   logic              reload;
   logic [BACK_W-1:0] back_s;

   plt_bus_regs #(
      .MUL_W(MUL_W), .DIV_W(DIV_W), .CNT_W(CNT_W), .CLR_FIRST(CLR_FIRST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_mul(cfg_mul), .cfg_div(cfg_div), .cfg_cnt(cfg_cnt),
      .ien_set(ien_set), .ien_clr(ien_clr),
      .lock_s(back_s[0]), .tag_s(back_s[1]),
      .mul_q(mul_q), .div_q(div_q), .cnt_q(cnt_q),
      .req_tgl(req_tgl), .chg_tgl(chg_tgl),
      .pll_en(pll_en), .mult_factor(mult_factor),
      .lock_status(lock_status), .irq(irq)
   );

   plt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
      .clk(slck), .rst_n(rst_n), .d(req_tgl), .q(req_s)
   );

   plt_lock_counter #(.CNT_W(CNT_W)) u_cnt (
      .slck(slck), .rst_n(rst_n),
      .req_s(req_s), .chg_in(chg_tgl), .cnt_in(cnt_q),
      .lock(lock_raw), .tag(tag_raw), .reload(reload)
   );

   plt_sync #(.W(BACK_W), .STAGES(SYNC_STAGES)) u_back_sync (
      .clk(clk), .rst_n(rst_n), .d({tag_raw, lock_raw}), .q(back_s)
   );

endmodule

// File: rtl/pll_lock_timer_chk.sv
module pll_lock_timer_chk #(
   parameter int MUL_W = 11,
   parameter int DIV_W = 8,
   parameter int CNT_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             slck,
   input logic             cfg_we,
   input logic [MUL_W-1:0] cfg_mul,
   input logic [DIV_W-1:0] cfg_div,
   input logic [MUL_W-1:0] mul_q,
   input logic [DIV_W-1:0] div_q,
   input logic [CNT_W-1:0] cnt_q,
   input logic             ien_set,
   input logic             ien_clr,
   input logic             lock_status,
   input logic             irq,
   input logic             lock_raw,
   input logic             reload
);

   logic [CNT_W:0]   elapsed;
   logic [CNT_W-1:0] snap;
   logic             armed;

   // slow edges since the last reload, saturating
   always_ff @(posedge slck or negedge rst_n) begin
      if (!rst_n) begin
         elapsed <= '0;
         snap    <= '0;
         armed   <= 1'b0;
      end else if (reload) begin
         elapsed <= '0;
         snap    <= cnt_q;
         armed   <= 1'b1;
      end else if (elapsed != '1) begin
         elapsed <= elapsed + 1'b1;
      end
   end

   // R2 and R3: the slow-domain lock rises exactly the programmed count after reload
   a_r2_lock_delay: assert property (@(posedge slck) disable iff (!rst_n)
      (armed && $rose(lock_raw)) |-> (elapsed == {1'b0, snap}));

   // R4: a ratio change removes the status in the next bus cycle
   a_r4_drop_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (cfg_mul != mul_q || cfg_div != div_q)) |=> !lock_status);

   // R5: a count-only write keeps an established lock
   a_r5_keep_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_mul == mul_q && cfg_div == div_q && lock_status) |=> lock_status);

   // R6: enabling makes the interrupt follow the status
   a_r6_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_set && !ien_clr) |=> (irq == lock_status));

   // R6: clearing (alone or with set) silences the interrupt
   a_r6_irq_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      ien_clr |=> !irq);

   // R6: no interrupt without the status bit
   a_r6_irq_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> lock_status);

endmodule

bind pll_lock_timer pll_lock_timer_chk #(
   .MUL_W(MUL_W), .DIV_W(DIV_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .slck(slck),
   .cfg_we(cfg_we), .cfg_mul(cfg_mul), .cfg_div(cfg_div),
   .mul_q(mul_q), .div_q(div_q), .cnt_q(cnt_q),
   .ien_set(ien_set), .ien_clr(ien_clr),
   .lock_status(lock_status), .irq(irq),
   .lock_raw(lock_raw), .reload(reload)
);

// File: tb/pll_lock_timer_test.sv
module pll_lock_timer_test;

   localparam int CLK_PERIOD = 10;
   localparam int SLOW_HALF  = 35;
   localparam int MUL_W = 11;
   localparam int DIV_W = 8;
   localparam int CNT_W = 6;
   localparam int NVEC  = 6;
   localparam int LIMIT = 150000;

   // vector table: multiplier, divider, wait count
   localparam int V_MUL [NVEC] = '{5, 5, 9, 9, 9, 0};
   localparam int V_DIV [NVEC] = '{1, 1, 1, 2, 2, 2};
   localparam int V_CNT [NVEC] = '{8, 3, 0, 5, 63, 1};

   logic clk = 1'b0;
   logic slck = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [MUL_W-1:0] cfg_mul = '0;
   logic [DIV_W-1:0] cfg_div = '0;
   logic [CNT_W-1:0] cfg_cnt = '0;
   logic ien_set = 1'b0;
   logic ien_clr = 1'b0;
   logic [MUL_W-1:0] mul_q;
   logic [DIV_W-1:0] div_q;
   logic [CNT_W-1:0] cnt_q;
   logic pll_en;
   logic [MUL_W:0] mult_factor;
   logic lock_status;
   logic irq;

   int checks = 0;
   int errors = 0;
   int prev_mul = 0;
   int prev_div = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   initial begin
      #2;
      forever #(SLOW_HALF) slck = ~slck;
   end

   pll_lock_timer #(.MUL_W(MUL_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) uut (
      .clk(clk), .rst_n(rst_n), .slck(slck),
      .cfg_we(cfg_we), .cfg_mul(cfg_mul), .cfg_div(cfg_div), .cfg_cnt(cfg_cnt),
      .ien_set(ien_set), .ien_clr(ien_clr),
      .mul_q(mul_q), .div_q(div_q), .cnt_q(cnt_q),
      .pll_en(pll_en), .mult_factor(mult_factor),
      .lock_status(lock_status), .irq(irq)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // write takes effect on the bus edge between the two negedges
   task automatic bus_write(input int m, input int d, input int c);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_mul = MUL_W'(m);
      cfg_div = DIV_W'(d);
      cfg_cnt = CNT_W'(c);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic strobe(input logic s, input logic c);
      @(negedge clk);
      ien_set = s;
      ien_clr = c;
      @(negedge clk);
      ien_set = 1'b0;
      ien_clr = 1'b0;
   endtask

   // number of slow edges after the write until the status is first seen high
   task automatic edges_to_lock(output int n);
      n = 0;
      for (int k = 0; k < 80; k++) begin
         @(posedge slck);
         n++;
         @(negedge slck);
         if (lock_status) break;
      end
   endtask

   initial begin
      #(CLK_PERIOD * LIMIT);
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      summary();
      $finish;
   end

   initial begin
      int n;
      bit moved;
      int exp_en;
      repeat (3) @(negedge clk);
      // R8: reset state
      check("R8 status in reset", int'(lock_status), 0);
      check("R8 irq in reset", int'(irq), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R8 status after reset", int'(lock_status), 0);
      check("R8 stored fields", int'(mul_q) + int'(div_q) + int'(cnt_q), 0);
      check("R8 factor", int'(mult_factor), 0);

      for (int v = 0; v < NVEC; v++) begin
         moved = (V_MUL[v] != prev_mul) || (V_DIV[v] != prev_div);
         bus_write(V_MUL[v], V_DIV[v], V_CNT[v]);
         // R1: all three fields from one write
         check("R1 mul_q", int'(mul_q), V_MUL[v]);
         check("R1 div_q", int'(div_q), V_DIV[v]);
         check("R1 cnt_q", int'(cnt_q), V_CNT[v]);
         exp_en = (V_MUL[v] != 0 && V_DIV[v] != 0) ? 1 : 0;
         check("R7 pll_en", int'(pll_en), exp_en);
         check("R7 mult_factor", int'(mult_factor), exp_en ? V_MUL[v] + 1 : 0);
         if (moved) begin
            check("R4 status drops after ratio change", int'(lock_status), 0);
            edges_to_lock(n);
            if (V_CNT[v] == 0) check("R3 zero count lock edge", n, 3);
            else               check("R2 lock edge", n, V_CNT[v] + 3);
         end else begin
            n = 1;
            for (int k = 0; k < 6; k++) begin
               @(negedge slck);
               if (!lock_status) n = 0;
            end
            check("R5 lock held on count-only write", n, 1);
         end
         prev_mul = V_MUL[v];
         prev_div = V_DIV[v];
      end

      // R6: interrupt enable strobes, status is high here
      check("R6 irq before enable", int'(irq), 0);
      strobe(1'b1, 1'b0);
      check("R6 irq after set", int'(irq), 1);
      strobe(1'b0, 1'b1);
      check("R6 irq after clear", int'(irq), 0);
      strobe(1'b1, 1'b0);
      strobe(1'b1, 1'b1);
      check("R6 clear wins over set", int'(irq), 0);
      strobe(1'b1, 1'b0);
      bus_write(7, 3, 2);
      check("R6 irq drops with status", int'(irq), 0);
      check("R4 status drops on divider change", int'(lock_status), 0);
      edges_to_lock(n);
      check("R2 relock after change", n, 5);
      check("R6 irq returns with lock", int'(irq), 1);

      summary();
      $finish;
   end

endmodule